// File: doc/BRIEF.md
# Calibrated Oscillator Prescaler

This block turns a 32,768-cycle-per-second oscillator clock into a one-second tick. It applies a digital rate trim so that a crystal which runs a little fast or slow can be brought back onto time. Two outputs are never trimmed:

- a sub-second stage pulse from the first divider stage;
- a square wave at 1/64 of the input rate, which a production tester can measure to find the crystal error.

The trim is set by a 5-bit magnitude and a direction bit. The block tracks its own place in a 64-minute window of 60-second minutes. In the first two-times-magnitude minutes of that window, the first second of each minute is altered:

- In speed-up mode that second loses one full first-stage period (256 input cycles).
- In slow-down mode that second gains half a first-stage period (128 input cycles).

The calendar logic downstream counts the seconds.

The one-second chain is controlled by a state machine with four states:

- `SEC_HALT` is the state out of reset, and the state while the stop input is high.
- `SEC_PLAIN` counts an untrimmed second.
- `SEC_FAST` counts a shortened second.
- `SEC_SLOW` counts a lengthened second.

Its transitions are:

- RESUME: from `SEC_HALT` to the kind of second at the current position, taken when stop is low.
- FREEZE: from any counting state to `SEC_HALT`, taken when stop is high.
- ROLL: at the last cycle of a second, to the kind of second at the next position.
- HOLD: stay in the same state in every other case.

Top module: `calib_prescaler`

## Requirements
- R1: In reset, tick_sec, tick_stage and ft_wave are low and the position is second 0 of minute 0. After reset is released, the first edge takes RESUME without counting, and the first tick_sec follows the L-th edge after release, where L is the length of that second.
- R2: With a magnitude of 0, every second lasts exactly 2^(STAGE_BITS+UPPER_BITS) input cycles (32,768 by default).
- R3: With cal_speedup = 1, a trimmed second is 2^STAGE_BITS input cycles shorter than the base second (256 by default).
- R4: With cal_speedup = 0, a trimmed second is 2^(STAGE_BITS-1) input cycles longer than the base second (128 by default).
- R5: A second is trimmed only when all of these hold:
  - its index within the minute is 0;
  - its minute index m within the MIN_PER_CYCLE-minute window satisfies m < 2*cal_mag;
  - cal_mag is not zero.
  With the defaults, a magnitude of 31 leaves minutes 62 and 63 untrimmed.
- R6: The calibration inputs are sampled once, when a second begins (at ROLL or RESUME). A change made in the middle of a second does not alter the length of that second.
- R7: While stop_osc is high, tick_sec, tick_stage and ft_wave stay low and both counters hold. A second that is interrupted by S stopped edges ends S+1 edges later than it would have without the stop; the extra edge is the RESUME edge.
- R8: tick_stage is a one-cycle pulse every 2^STAGE_BITS running cycles, taken from the free-running first stage. Its spacing is independent of the calibration setting.
- R9: ft_wave is enabled only when all of these hold:
  - stop_osc is 0;
  - ft_enable is 1;
  - alarm_irq_en is 0;
  - wd_steer_rst is 1, or wd_count_zero is 1.
  When enabled, ft_wave is a square wave with a period of 2^(STAGE_BITS-2) cycles, unaffected by the trim. When not enabled, ft_wave is low.
- R10: tick_sec is high for one cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stop_osc | input | 1 | Halts all counting while high |
| cal_mag | input | 5 | Trim magnitude, 0 to 31 |
| cal_speedup | input | 1 | 1 shortens trimmed seconds, 0 lengthens them |
| ft_enable | input | 1 | Test-wave request |
| alarm_irq_en | input | 1 | Alarm interrupt enable; blocks the test wave when high |
| wd_steer_rst | input | 1 | Watchdog steered to reset; allows the test wave |
| wd_count_zero | input | 1 | Watchdog setting is zero; allows the test wave |
| tick_sec | output | 1 | One-cycle pulse at the end of each trimmed or plain second |
| tick_stage | output | 1 | One-cycle pulse at each wrap of the first divider stage |
| ft_wave | output | 1 | Untrimmed test square wave |

## Verification
The assertions check the following on every cycle:
- the stop input silences all three outputs and freezes the first stage;
- the second counter never passes the longest second;
- the position counters stay within their ranges;
- a trimmed state occurs only on the first second of a minute;
- tick_sec never lasts two cycles.

Only the bench scenarios can show the following:
- the lengths of the seconds and which minutes are trimmed, in both directions and at magnitudes of 0, 1, 2, 3 and 31;
- that calibration is sampled once per second;
- the exact one-edge cost of a stop;
- that the test wave keeps a fixed period through trimmed seconds.

// File: rtl/presc_pkg.sv
package presc_pkg;

    localparam int CAL_MAG_W = 5;

    typedef enum logic [1:0] {
        SEC_HALT  = 2'd0,
        SEC_PLAIN = 2'd1,
        SEC_FAST  = 2'd2,
        SEC_SLOW  = 2'd3
    } sec_kind_e;

    // Decide which kind of second starts at a given position.
    function automatic sec_kind_e pick_kind(
        input logic                 first_of_min,
        input int unsigned          min_idx,
        input logic [CAL_MAG_W-1:0] mag,
        input logic                 speedup
    );
        sec_kind_e kind;
        kind = SEC_PLAIN;
        if (first_of_min && (mag != '0) && (min_idx < (32'(mag) << 1))) begin
            kind = speedup ? SEC_FAST : SEC_SLOW;
        end
        return kind;
    endfunction

endpackage

// File: rtl/presc_stage_ctr.sv
module presc_stage_ctr #(
    parameter int STAGE_BITS = 8
) (
    input  logic clk_osc,
    input  logic rst_n,
    input  logic run,
    output logic stage_wrap,
    output logic ft_src
);

    localparam logic [STAGE_BITS-1:0] STAGE_TOP = '1;
    localparam int FT_BIT = STAGE_BITS - 3;

    logic [STAGE_BITS-1:0] stage_cnt;

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) begin
            stage_cnt <= '0;
        end else if (run) begin
            stage_cnt <= stage_cnt + 1'b1;
        end
    end

    assign stage_wrap = run && (stage_cnt == STAGE_TOP);
    assign ft_src     = stage_cnt[FT_BIT];

    // R7: the first stage holds while stopped
    assert_stage_frozen_R7: assert property (@(posedge clk_osc) disable iff (!rst_n)
        !run |=> $stable(stage_cnt));

endmodule

// File: rtl/presc_position.sv
module presc_position #(
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64
) (
    input  logic clk_osc,
    input  logic rst_n,
    input  logic advance,
    output logic first_now,
    output logic [$clog2(MIN_PER_CYCLE)-1:0] min_now,
    output logic first_nxt,
    output logic [$clog2(MIN_PER_CYCLE)-1:0] min_nxt
);

    localparam int SEC_W = $clog2(SEC_PER_MIN);
    localparam int MIN_W = $clog2(MIN_PER_CYCLE);
    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_PER_MIN - 1);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(MIN_PER_CYCLE - 1);

    logic [SEC_W-1:0] sec_idx, sec_nxt;
    logic [MIN_W-1:0] min_idx;
    logic             sec_wraps;

    always_comb begin
        sec_wraps = (sec_idx == SEC_LAST);
        sec_nxt   = sec_wraps ? '0 : sec_idx + 1'b1;
        min_nxt   = min_idx;
        if (sec_wraps) begin
            min_nxt = (min_idx == MIN_LAST) ? '0 : min_idx + 1'b1;
        end
    end

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) begin
            sec_idx <= '0;
            min_idx <= '0;
        end else if (advance) begin
            sec_idx <= sec_nxt;
            min_idx <= min_nxt;
        end
    end

    assign first_now = (sec_idx == '0);
    assign first_nxt = (sec_nxt == '0);
    assign min_now   = min_idx;

    // R5: position stays inside the window
    assert_pos_range_R5: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (sec_idx <= SEC_LAST) && (min_idx <= MIN_LAST));

endmodule

// File: rtl/presc_sec_fsm.sv
module presc_sec_fsm
    import presc_pkg::*;
#(
    parameter int STAGE_BITS = 8,
    parameter int UPPER_BITS = 7,
    parameter int MIN_W      = 6
) (
    input  logic                 clk_osc,
    input  logic                 rst_n,
    input  logic                 stop_osc,
    input  logic [CAL_MAG_W-1:0] cal_mag,
    input  logic                 cal_speedup,
    input  logic                 first_now,
    input  logic [MIN_W-1:0]     min_now,
    input  logic                 first_nxt,
    input  logic [MIN_W-1:0]     min_nxt,
    output logic                 sec_done
);

    localparam int CNT_W = STAGE_BITS + UPPER_BITS + 1;
    localparam logic [CNT_W-1:0] BASE_LEN = CNT_W'(1) << (STAGE_BITS + UPPER_BITS);
    localparam logic [CNT_W-1:0] FAST_LEN = BASE_LEN - (CNT_W'(1) << STAGE_BITS);
    localparam logic [CNT_W-1:0] SLOW_LEN = BASE_LEN + (CNT_W'(1) << (STAGE_BITS - 1));

    sec_kind_e        state, state_nxt, kind_now, kind_next;
    logic [CNT_W-1:0] cyc_cnt, len_m1;
    logic             counting, at_end;

    always_comb begin
        kind_now  = pick_kind(first_now, int'(min_now), cal_mag, cal_speedup);
        kind_next = pick_kind(first_nxt, int'(min_nxt), cal_mag, cal_speedup);
    end

    always_comb begin
        unique case (state)
            SEC_FAST: len_m1 = FAST_LEN - 1'b1;
            SEC_SLOW: len_m1 = SLOW_LEN - 1'b1;
            default:  len_m1 = BASE_LEN - 1'b1;
        endcase
        counting = (state != SEC_HALT) && !stop_osc;
        at_end   = counting && (cyc_cnt >= len_m1);
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            SEC_HALT: begin
                if (!stop_osc) state_nxt = kind_now;      // RESUME
            end
            SEC_PLAIN, SEC_FAST, SEC_SLOW: begin
                if (stop_osc)    state_nxt = SEC_HALT;    // FREEZE
                else if (at_end) state_nxt = kind_next;   // ROLL
            end
        endcase
    end

    // State register
    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) state <= SEC_HALT;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n)        cyc_cnt <= '0;
        else if (at_end)   cyc_cnt <= '0;
        else if (counting) cyc_cnt <= cyc_cnt + 1'b1;
    end

    // Outputs
    always_comb begin
        sec_done = at_end;
    end

    assert_cnt_bound_R4: assert property (@(posedge clk_osc) disable iff (!rst_n)
        cyc_cnt <= SLOW_LEN - 1'b1);
    assert_trim_first_sec_R5: assert property (@(posedge clk_osc) disable iff (!rst_n)
        ((state == SEC_FAST) || (state == SEC_SLOW)) |-> first_now);
    assert_halt_no_tick_R7: assert property (@(posedge clk_osc) disable iff (!rst_n)
        (state == SEC_HALT) |-> !sec_done);

endmodule

// File: rtl/presc_ft_gate.sv
module presc_ft_gate (
    input  logic stop_osc,
    input  logic ft_enable,
    input  logic alarm_irq_en,
    input  logic wd_steer_rst,
    input  logic wd_count_zero,
    input  logic ft_src,
    output logic ft_wave
);

    logic allowed;

    always_comb begin
        allowed = !stop_osc && ft_enable && !alarm_irq_en && (wd_steer_rst || wd_count_zero);
        ft_wave = allowed && ft_src;
    end

endmodule

// File: rtl/calib_prescaler.sv
module calib_prescaler
    import presc_pkg::*;
#(
    parameter int STAGE_BITS    = 8,
    parameter int UPPER_BITS    = 7,
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_CYCLE = 64
) (
    input  logic                 clk_osc,
    input  logic                 rst_n,
    input  logic                 stop_osc,
    input  logic [CAL_MAG_W-1:0] cal_mag,
    input  logic                 cal_speedup,
    input  logic                 ft_enable,
    input  logic                 alarm_irq_en,
    input  logic                 wd_steer_rst,
    input  logic                 wd_count_zero,
    output logic                 tick_sec,
    output logic                 tick_stage,
    output logic                 ft_wave
);

    localparam int MIN_W = $clog2(MIN_PER_CYCLE);

    logic             ft_src, first_now, first_nxt, sec_done;
    logic [MIN_W-1:0] min_now, min_nxt;

    presc_stage_ctr #(.STAGE_BITS(STAGE_BITS)) u_stage (
        .clk_osc   (clk_osc),
        .rst_n     (rst_n),
        .run       (!stop_osc),
        .stage_wrap(tick_stage),
        .ft_src    (ft_src)
    );

    presc_position #(.SEC_PER_MIN(SEC_PER_MIN), .MIN_PER_CYCLE(MIN_PER_CYCLE)) u_pos (
        .clk_osc  (clk_osc),
        .rst_n    (rst_n),
        .advance  (sec_done),
        .first_now(first_now),
        .min_now  (min_now),
        .first_nxt(first_nxt),
        .min_nxt  (min_nxt)
    );

    presc_sec_fsm #(.STAGE_BITS(STAGE_BITS), .UPPER_BITS(UPPER_BITS), .MIN_W(MIN_W)) u_fsm (
        .clk_osc    (clk_osc),
        .rst_n      (rst_n),
        .stop_osc   (stop_osc),
        .cal_mag    (cal_mag),
        .cal_speedup(cal_speedup),
        .first_now  (first_now),
        .min_now    (min_now),
        .first_nxt  (first_nxt),
        .min_nxt    (min_nxt),
        .sec_done   (sec_done)
    );

    presc_ft_gate u_ft (
        .stop_osc     (stop_osc),
        .ft_enable    (ft_enable),
        .alarm_irq_en (alarm_irq_en),
        .wd_steer_rst (wd_steer_rst),
        .wd_count_zero(wd_count_zero),
        .ft_src       (ft_src),
        .ft_wave      (ft_wave)
    );

    assign tick_sec = sec_done;

    assert_stop_quiet_R7: assert property (@(posedge clk_osc) disable iff (!rst_n)
        stop_osc |-> (!tick_sec && !tick_stage && !ft_wave));
    assert_tick_single_R10: assert property (@(posedge clk_osc) disable iff (!rst_n)
        tick_sec |=> !tick_sec);

endmodule

// File: tb/calib_prescaler_bench.sv
module calib_prescaler_bench;

    localparam int SB = 4, UB = 2, SPM = 3, MPC = 8;
    localparam int BASE = 1 << (SB + UB);
    localparam int FAST = BASE - (1 << SB);
    localparam int SLOW = BASE + (1 << (SB - 1));
    localparam int FT_PERIOD = 1 << (SB - 2);

    typedef struct packed {
        logic [4:0]  mag;
        logic        up;
        logic [15:0] total;
    } vec_t;

    // totals over one window of SPM*MPC = 24 seconds
    localparam vec_t VECS [6] = '{
        '{5'd0,  1'b1, 16'd1536},
        '{5'd1,  1'b1, 16'd1504},
        '{5'd1,  1'b0, 16'd1552},
        '{5'd3,  1'b1, 16'd1440},
        '{5'd2,  1'b0, 16'd1568},
        '{5'd31, 1'b0, 16'd1600}
    };

    logic clk_osc = 1'b0;
    logic rst_n = 1'b0;
    logic stop_osc = 1'b0;
    logic [4:0] cal_mag = '0;
    logic cal_speedup = 1'b0;
    logic ft_enable = 1'b0, alarm_irq_en = 1'b0, wd_steer_rst = 1'b0, wd_count_zero = 1'b0;
    logic tick_sec, tick_stage, ft_wave;

    int total = 0;
    int bad = 0;

    always #2 clk_osc = ~clk_osc;

    calib_prescaler #(.STAGE_BITS(SB), .UPPER_BITS(UB), .SEC_PER_MIN(SPM), .MIN_PER_CYCLE(MPC))
    u_calib_prescaler (
        .clk_osc(clk_osc), .rst_n(rst_n), .stop_osc(stop_osc), .cal_mag(cal_mag),
        .cal_speedup(cal_speedup), .ft_enable(ft_enable), .alarm_irq_en(alarm_irq_en),
        .wd_steer_rst(wd_steer_rst), .wd_count_zero(wd_count_zero),
        .tick_sec(tick_sec), .tick_stage(tick_stage), .ft_wave(ft_wave)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_len(input int k, input int mag, input bit up);
        int s = k % SPM;
        int m = (k / SPM) % MPC;
        if (s == 0 && mag != 0 && m < 2 * mag) return up ? FAST : SLOW;
        return BASE;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk_osc);
        rst_n = 1'b1;
    endtask

    // counts edges until tick_sec is seen, sampling at negedges
    task automatic wait_tick(output int n);
        n = 0;
        do begin
            @(negedge clk_osc);
            n++;
        end while (!tick_sec && n < 1000);
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, sum, miss, prev, cnt;
        logic last_ft;

        // R1: reset state
        rst_n = 1'b0;
        repeat (2) @(negedge clk_osc);
        check("R1 reset outputs", {tick_sec, tick_stage, ft_wave}, 0);

        // Table walk: R2 R3 R4 R5 lengths per second over one window
        foreach (VECS[i]) begin
            cal_mag = VECS[i].mag;
            cal_speedup = VECS[i].up;
            do_reset();
            sum = 0;
            miss = 0;
            for (int k = 0; k < SPM * MPC; k++) begin
                wait_tick(n);
                sum += n;
                if (n != model_len(k, VECS[i].mag, VECS[i].up)) begin
                    miss++;
                    $display("FAIL R5 vec %0d sec %0d actual=%0d expected=%0d",
                             i, k, n, model_len(k, VECS[i].mag, VECS[i].up));
                end
            end
            check("R2/R3/R4 window length", sum, int'(VECS[i].total));
            check("R5 per-second mismatches", miss, 0);
        end

        // R1 / R6: first second trimmed, calibration changed mid-second
        cal_mag = 5'd1;
        cal_speedup = 1'b1;
        do_reset();
        n = 0;
        repeat (10) begin @(negedge clk_osc); n++; end
        cal_mag = 5'd0;
        do begin @(negedge clk_osc); n++; end while (!tick_sec && n < 1000);
        check("R6 mid-second cal change", n, FAST);
        @(negedge clk_osc);
        check("R10 tick one cycle", int'(tick_sec), 0);

        // R7: stop stretches the second by S+1 and silences outputs
        cal_mag = 5'd0;
        ft_enable = 1'b1;
        wd_steer_rst = 1'b1;
        do_reset();
        wait_tick(n);
        check("R1 first tick", n, BASE);
        n = 0;
        repeat (10) begin @(negedge clk_osc); n++; end
        stop_osc = 1'b1;
        cnt = 0;
        repeat (20) begin
            @(negedge clk_osc);
            n++;
            if (tick_sec || tick_stage || ft_wave) cnt++;
        end
        stop_osc = 1'b0;
        check("R7 outputs quiet while stopped", cnt, 0);
        do begin @(negedge clk_osc); n++; end while (!tick_sec && n < 1000);
        check("R7 stretched second", n, BASE + 21);

        // R8 / R9: stage spacing and test wave through trimmed seconds
        cal_mag = 5'd31;
        cal_speedup = 1'b1;
        do_reset();
        prev = -1;
        miss = 0;
        cnt = 0;
        for (int c = 1; c <= 320; c++) begin
            @(negedge clk_osc);
            if (tick_stage) begin
                if (prev >= 0 && c - prev != (1 << SB)) miss++;
                prev = c;
                cnt++;
            end
        end
        check("R8 stage spacing errors", miss, 0);
        check("R8 stage pulse count", cnt, 320 / (1 << SB));

        last_ft = ft_wave;
        prev = -1;
        miss = 0;
        cnt = 0;
        for (int c = 1; c <= 256; c++) begin
            @(negedge clk_osc);
            if (ft_wave && !last_ft) begin
                if (prev >= 0 && c - prev != FT_PERIOD) miss++;
                prev = c;
                cnt++;
            end
            last_ft = ft_wave;
        end
        check("R9 wave period errors", miss, 0);
        check("R9 wave rising count", cnt, 256 / FT_PERIOD);

        // R9: each blocking condition holds the wave low
        for (int t = 0; t < 4; t++) begin
            ft_enable = (t != 0);
            alarm_irq_en = (t == 1);
            wd_steer_rst = (t == 3);
            wd_count_zero = 1'b0;
            if (t == 3) cal_speedup = 1'b0;
            cnt = 0;
            repeat (16) begin @(negedge clk_osc); if (ft_wave) cnt++; end
            if (t < 3) check("R9 wave blocked", cnt, 0);
            else       check("R9 wave allowed by steering", cnt, 16 / 2);
        end
        wd_steer_rst = 1'b0;
        wd_count_zero = 1'b1;
        cnt = 0;
        repeat (16) begin @(negedge clk_osc); if (ft_wave) cnt++; end
        check("R9 wave allowed by zero watchdog", cnt, 16 / 2);
        wd_count_zero = 1'b0;
        cnt = 0;
        repeat (16) begin @(negedge clk_osc); if (ft_wave) cnt++; end
        check("R9 wave blocked without watchdog term", cnt, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule